// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counter that advances on ticks taken from a selectable prescaler (divide by 1, 4 or 16 of an input clock enable). On each tick the count is compared with a programmable period value. When the two are equal, the counter goes back to zero on the following tick and a one-cycle match pulse is produced, so one full period is the period value plus one ticks. Other logic can use this unscaled pulse as a time base, for example for pulse-width generation or as a serial shift clock.

Match events also step a 4-bit postscaler. After a programmed number of matches (1 to 16) the postscaler sets a sticky interrupt flag. The flag stays set until software clears it. The interrupt output is the flag gated by an enable bit. A small register bus gives read and write access to the count, the period, the control fields and the flag/enable pair. A write to the count or to the control register restarts the prescaler and the postscaler from zero. A control write leaves the count unchanged.

Register map (2-bit address): 0 = count, 1 = period, 2 = control, 3 = flag/enable.

Top module: `match_timer`

## Requirements
- R1: After reset the count reads 00h, the period reads FFh, the control register reads 00h and the flag/enable register reads 00h; matchPulse and irq are low.
- R2: Control bits [1:0] select the prescale ratio: 00 gives one tick per enabled cycle, 01 one tick per 4 enabled cycles, 1x one tick per 16 enabled cycles. Cycles with clkEn low are not counted.
- R3: On a tick where the count equals the period, the count returns to 00h and matchPulse is high for exactly the next cycle. With clkEn held high, consecutive match pulses are (period+1) times the prescale ratio cycles apart.
- R4: Control bits [6:3] hold N. The flag is set on the (N+1)-th match after the postscaler was cleared, and it is set again after every further N+1 matches.
- R5: Flag/enable register bit 0 is the flag and bit 1 is the enable. The flag stays set until a write puts 0 in bit 0. irq is high only when both bits are set. A hardware set in the same cycle as a clearing write wins.
- R6: Any write to the count register or to the control register clears the prescaler and postscaler counters. The next tick then comes a full prescale ratio later, and the next flag comes a full N+1 matches later.
- R7: A write to the control register leaves the count unchanged.
- R8: Control bit 2 is the run bit. While it is 0, the count holds its value and no match pulse or flag is produced.
- R9: A bus write to the count register in a cycle that would otherwise increment or reload the count takes effect, and that cycle produces no match.
- R10: matchPulse fires on every match, whatever the postscaler ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkEn | input | 1 | Input clock enable fed into the prescaler |
| busAddr | input | 2 | Register select for read and write |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data of the selected register (combinational) |
| matchPulse | output | 1 | One-cycle pulse on each period match, before the postscaler |
| irq | output | 1 | Interrupt: flag AND enable |

## Verification
If the prescaler or counter state is wrong, the spacing between match pulses is wrong, and this shows up within one period of the timer. If the postscaler state is wrong, the number of matches before irq rises is off, and this shows up within sixteen periods. If the clear-on-write paths are broken, the first tick or flag after a register write arrives early, and this can be seen within one prescale ratio or one postscale group. If write priority is wrong, a count read right after the write edge returns a value other than the one written.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
  localparam int CNT_W  = 8;
  localparam int PRE_W  = 4;
  localparam int POST_W = 4;

  localparam logic [1:0] ADDR_COUNT  = 2'd0;
  localparam logic [1:0] ADDR_PERIOD = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;
  localparam logic [1:0] ADDR_FLAG   = 2'd3;

  typedef struct packed {
    logic             tick;
    logic             cntWr;
    logic             perWr;
    logic [CNT_W-1:0] wrData;
  } mtmrStrobe_t;

  // prescale terminal count for a 2-bit selector: 0 -> 1, 1 -> 4, 2/3 -> 16
  function automatic logic [PRE_W-1:0] preLimit(input logic [1:0] sel);
    logic [PRE_W-1:0] lim;
    case (sel)
      2'd0:    lim = '0;
      2'd1:    lim = PRE_W'(3);
      default: lim = PRE_W'(15);
    endcase
    return lim;
  endfunction
endpackage

// File: rtl/mtmr_dp.sv
module mtmr_dp
  import mtmr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  mtmrStrobe_t      strobe,
  output logic             matchEv,
  output logic             matchPulse,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] period
);
  logic equalNow;

  assign equalNow = (count == period);
  assign matchEv  = strobe.tick && equalNow && !strobe.cntWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.cntWr) begin
      count <= strobe.wrData;
    end else if (strobe.tick) begin
      count <= equalNow ? '0 : count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      period <= '1;
    end else if (strobe.perWr) begin
      period <= strobe.wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) matchPulse <= 1'b0;
    else       matchPulse <= matchEv;
  end

  a_r3_reload_zero: assert property (@(posedge clk) disable iff (!rstN)
    matchEv |=> (count == '0 && matchPulse));
  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntWr |=> (count == $past(strobe.wrData) && !matchPulse));
  a_r8_hold_count: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tick && !strobe.cntWr) |=> $stable(count));
endmodule

// File: rtl/mtmr_ctrl.sv
module mtmr_ctrl
  import mtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic [1:0]        busAddr,
  input  logic              busWrEn,
  input  logic [CNT_W-1:0]  busWrData,
  output logic [CNT_W-1:0]  busRdData,
  input  logic              matchEv,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  period,
  output mtmrStrobe_t       strobe,
  output logic              irq
);
  logic [1:0]        preSel;
  logic              runEn;
  logic [POST_W-1:0] postSel;
  logic              flagQ;
  logic              irqEn;
  logic [PRE_W-1:0]  preCnt;
  logic [POST_W-1:0] postCnt;
  logic [PRE_W-1:0]  preTop;
  logic cntWr, perWr, ctrlWr, flagWr, clrScalers, preWrap, setFlag;

  assign cntWr      = busWrEn && (busAddr == ADDR_COUNT);
  assign perWr      = busWrEn && (busAddr == ADDR_PERIOD);
  assign ctrlWr     = busWrEn && (busAddr == ADDR_CTRL);
  assign flagWr     = busWrEn && (busAddr == ADDR_FLAG);
  assign clrScalers = cntWr || ctrlWr;

  assign preTop  = preLimit(preSel);
  assign preWrap = (preCnt == preTop);

  assign strobe.tick   = runEn && clkEn && preWrap && !clrScalers;
  assign strobe.cntWr  = cntWr;
  assign strobe.perWr  = perWr;
  assign strobe.wrData = busWrData;

  assign setFlag = matchEv && (postCnt == postSel);

  // control fields
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preSel  <= '0;
      runEn   <= 1'b0;
      postSel <= '0;
    end else if (ctrlWr) begin
      preSel  <= busWrData[1:0];
      runEn   <= busWrData[2];
      postSel <= busWrData[6:3];
    end
  end

  // prescaler
  always_ff @(posedge clk) begin
    if (!rstN || clrScalers) begin
      preCnt <= '0;
    end else if (runEn && clkEn) begin
      preCnt <= preWrap ? '0 : preCnt + 1'b1;
    end
  end

  // postscaler
  always_ff @(posedge clk) begin
    if (!rstN || clrScalers) begin
      postCnt <= '0;
    end else if (matchEv) begin
      postCnt <= setFlag ? '0 : postCnt + 1'b1;
    end
  end

  // sticky flag and enable
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= 1'b0;
      irqEn <= 1'b0;
    end else begin
      if (flagWr) irqEn <= busWrData[1];
      if (setFlag)     flagQ <= 1'b1;
      else if (flagWr) flagQ <= busWrData[0];
    end
  end

  assign irq = flagQ && irqEn;

  always_comb begin
    case (busAddr)
      ADDR_COUNT:  busRdData = count;
      ADDR_PERIOD: busRdData = period;
      ADDR_CTRL:   busRdData = {1'b0, postSel, runEn, preSel};
      default:     busRdData = {{(CNT_W-2){1'b0}}, irqEn, flagQ};
    endcase
  end

  a_r6_prescaler_clear: assert property (@(posedge clk) disable iff (!rstN)
    clrScalers |=> (preCnt == '0 && postCnt == '0));
  a_r4_flag_from_match: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> $past(matchEv));
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !(flagWr && !busWrData[0])) |=> flagQ);
  a_r8_no_tick_stopped: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> !strobe.tick);
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mtmr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEn,
  input  logic [1:0]       busAddr,
  input  logic             busWrEn,
  input  logic [CNT_W-1:0] busWrData,
  output logic [CNT_W-1:0] busRdData,
  output logic             matchPulse,
  output logic             irq
);
  mtmrStrobe_t      strobe;
  logic             matchEv;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] period;

  mtmr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .clkEn(clkEn),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .matchEv(matchEv), .count(count),
    .period(period), .strobe(strobe), .irq(irq)
  );

  mtmr_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .matchEv(matchEv),
    .matchPulse(matchPulse), .count(count), .period(period)
  );
endmodule

// File: tb/tb_match_timer.sv
module tb_match_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clkEn = 1'b1;
  logic [1:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       matchPulse, irq;
  logic       gateMode = 1'b0;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  always @(negedge clk) clkEn <= gateMode ? ~clkEn : 1'b1;

  match_timer dut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .matchPulse(matchPulse), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a negedge; write lands on the next posedge, returns at the following negedge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    busAddr = a;
    #1 v = busRdData;
  endtask

  function automatic int divOf(input int pre);
    return (pre == 0) ? 1 : (pre == 1) ? 4 : 16;
  endfunction

  task automatic runCfg(input int p, input int pre, input int post);
    int last, mcnt, cyc, limit;
    bit seen;
    wr(2, 8'h00);
    wr(1, 8'(p));
    wr(3, 8'h02);
    wr(0, 8'h00);
    wr(2, 8'((post << 3) | 4 | pre));
    last = -1; mcnt = 0; seen = 0;
    limit = (p + 1) * divOf(pre) * (post + 4) + 40;
    for (cyc = 0; cyc < limit; cyc++) begin
      if (matchPulse) begin
        mcnt++;
        if (last >= 0) check("R3 match spacing", cyc - last, (p + 1) * divOf(pre));
        last = cyc;
      end
      if (irq && !seen) begin
        seen = 1;
        check("R4 matches to flag", mcnt, post + 1);
        check("R10 pulse count before flag", matchPulse, 1);
      end
      if (seen && mcnt >= post + 3) break;
      @(negedge clk);
    end
    check("R4 flag raised", seen, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int v, c0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset values
    rd(0, v); check("R1 count reset", v, 0);
    rd(1, v); check("R1 period reset", v, 255);
    rd(2, v); check("R1 ctrl reset", v, 0);
    rd(3, v); check("R1 flag reset", v, 0);
    check("R1 matchPulse reset", matchPulse, 0);
    check("R1 irq reset", irq, 0);
    @(negedge clk);

    // R2 R3 R4 R10 sweep
    for (int p = 0; p < 8; p += 3)
      for (int pre = 0; pre < 4; pre++)
        for (int post = 0; post < 4; post += 3)
          runCfg(p, pre, post);
    runCfg(2, 0, 15);

    // R2 clkEn gating: half-rate enable, ratio 1, period 3 -> 8 cycles
    begin
      int last, n;
      gateMode = 1'b1;
      wr(2, 8'h00); wr(1, 8'd3); wr(0, 8'h00); wr(2, 8'h04);
      last = -1; n = 0;
      for (int cyc = 0; cyc < 60; cyc++) begin
        if (matchPulse) begin
          if (last >= 0) begin check("R2 gated spacing", cyc - last, 8); n++; end
          last = cyc;
        end
        @(negedge clk);
      end
      check("R2 gated pulses seen", n > 2, 1);
      gateMode = 1'b0;
      @(negedge clk); @(negedge clk);
    end

    // R7 / R8: stop while counting, count preserved and held
    wr(2, 8'h00); wr(1, 8'hFF); wr(3, 8'h02); wr(0, 8'h00); wr(2, 8'h04);
    repeat (10) @(negedge clk);
    rd(0, c0);
    wr(2, 8'h00);
    rd(0, v); check("R7 ctrl write keeps count", v, c0);
    repeat (20) @(negedge clk);
    rd(0, v); check("R8 count held when stopped", v, c0);
    check("R8 no match when stopped", matchPulse, 0);
    check("R8 no irq when stopped", irq, 0);

    // R6 prescaler cleared by count write (ratio 16)
    wr(2, 8'h06);
    repeat (9) @(negedge clk);
    wr(0, 8'h00);
    repeat (15) @(negedge clk);
    rd(0, v); check("R6 no early tick after count write", v, 0);
    @(negedge clk);
    rd(0, v); check("R6 tick one full ratio later", v, 1);
    // R6 prescaler cleared by ctrl write
    repeat (7) @(negedge clk);
    rd(0, c0);
    wr(2, 8'h06);
    repeat (15) @(negedge clk);
    rd(0, v); check("R6 ctrl write clears prescaler", v, c0);
    @(negedge clk);
    rd(0, v); check("R6 tick after ctrl write", v, c0 + 1);

    // R6 postscaler cleared by ctrl write: N=3, two matches then restart
    begin
      int mcnt;
      bit seen;
      wr(2, 8'h00); wr(1, 8'd1); wr(3, 8'h02); wr(0, 8'h00); wr(2, 8'h1C);
      mcnt = 0;
      while (mcnt < 2) begin if (matchPulse) mcnt++; @(negedge clk); end
      wr(2, 8'h1C);
      wr(0, 8'h00);
      mcnt = 0; seen = 0;
      for (int cyc = 0; cyc < 40 && !seen; cyc++) begin
        if (matchPulse) mcnt++;
        if (irq) begin seen = 1; check("R6 postscaler restarted", mcnt, 4); end
        @(negedge clk);
      end
      check("R6 flag after restart", seen, 1);
    end

    // R5 sticky flag, enable gating, clear
    wr(2, 8'h00);
    repeat (5) @(negedge clk);
    rd(3, v); check("R5 flag sticky", v, 3);
    wr(3, 8'h01);
    check("R5 irq masked by enable", irq, 0);
    rd(3, v); check("R5 flag still set with enable off", v, 1);
    wr(3, 8'h02);
    rd(3, v); check("R5 flag cleared by write", v, 2);
    check("R5 irq low after clear", irq, 0);

    // R9 count write beats increment and reload
    wr(1, 8'd5); wr(0, 8'd5);
    wr(2, 8'h04);
    wr(0, 8'h33);
    rd(0, v); check("R9 write wins over reload", v, 8'h33);
    check("R9 no match on written cycle", matchPulse, 0);
    wr(0, 8'h40);
    rd(0, v); check("R9 write wins over increment", v, 8'h40);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule